// File: doc/BRIEF.md
# Half-Rate Rotational Frequency Detector

This block is the digital frequency-steering stage of a half-rate clock and data recovery loop. Each time the incoming NRZ data toggles, an upstream sampler captures a recovered clock that runs near half the data rate at four phases 45° apart. That capture arrives here as a one-cycle strobe with four phase bits. The block folds the four bits into a two-bit quadrant code and keeps the quadrant seen at the previous data transition. From the direction in which the quadrant moves around the phase circle it decides whether the recovered clock is slow or fast.

When the quadrant crosses one particular boundary in the slow direction, the block raises `up_o` for one cycle. When it crosses that boundary in the fast direction, it raises `dn_o` for one cycle. Near lock the sampled phase barely moves between transitions and never crosses the boundary. The detector then stays silent without any enable or lock input, so it can be left connected next to the phase detector.

The sample input is a valid-only stream. The block accepts a beat in every cycle that `smp_valid` is high and never applies back-pressure, so it has no ready output. The producer may present beats back to back or with any number of idle cycles between them.

Top module: `rfd_top`

## Requirements
- R1: The quadrant code is {X1,X2}, where X1 = sample0° XOR sample90° and X2 = sample45° XOR sample135°. `smp_phase[k]` is the sample taken at k·45°. As phase advances the code runs 00 → 01 → 11 → 10 → 00.
- R2: Samples are taken only in cycles with `smp_valid` high. Idle cycles leave the stored previous quadrant unchanged and produce no pulse.
- R3: Two consecutive accepted beats with quadrant 10 then 00 raise `up_o` in the cycle after the second beat is accepted, for exactly one cycle.
- R4: Two consecutive accepted beats with quadrant 00 then 10 raise `dn_o` in the cycle after the second beat is accepted, for exactly one cycle.
- R5: Every other pair of consecutive quadrants, including an unchanged quadrant, produces neither pulse.
- R6: `up_o` and `dn_o` are never high in the same cycle.
- R7: Synchronous active-high `rst` clears both outputs and forgets the previous quadrant. The first beat after reset only records its quadrant and produces no pulse.
- R8: With a clock-to-data frequency ratio below 0.5 (quadrant stepping forward by less than 90° per transition), only `up_o` pulses occur. With a ratio above 0.5 only `dn_o` pulses occur. At exactly 0.5 no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a data transition |
| smp_phase | input | NPH (4) | Clock samples; bit k taken at k·45° |
| up_o | output | 1 | One-cycle pulse: clock slow, speed up |
| dn_o | output | 1 | One-cycle pulse: clock fast, slow down |

## Verification
The bench targets the single boundary between codes 10 and 00. A design with the directions swapped, or one that also fires across the 01/11 crossing, shows up at once against the table walk and the modelled frequency sweeps. It then issues idle cycles whose phase bits would form a crossing if they were taken. A design that samples without the strobe updates its history and fires a spurious UP. A reset in the middle of a run, right before a boundary crossing, catches a design that keeps its history or lacks the first-beat guard, because that design pulses where it must stay quiet. Sweeps at ratio 0.5 and at steps of ±18° and ±36° per transition confirm one-sided pulsing and silence at lock.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  // Number of clock phase samples per strobe (45 degree spacing).
  localparam int PH_N = 4;
  // Quadrant code width: one XOR per pair of phases 90 degrees apart.
  localparam int QW   = PH_N / 2;

  // Steering decision for one accepted beat.
  typedef enum logic [1:0] {
    STEER_NONE = 2'b00,
    STEER_UP   = 2'b01,
    STEER_DN   = 2'b10
  } steer_e;
endpackage

// File: rtl/rfd_quadrant.sv
module rfd_quadrant #(
  parameter int NPH = rfd_pkg::PH_N,
  localparam int QW = NPH / 2
) (
  input  logic [NPH-1:0] phase_i,
  output logic [QW-1:0]  quad_o
);
  // Pair each phase with the one 90 degrees later; the first pair
  // lands in the most significant bit of the code.
  for (genvar k = 0; k < QW; k++) begin : g_pair
    assign quad_o[QW-1-k] = phase_i[k] ^ phase_i[k+QW];
  end
endmodule

// File: rtl/rfd_history.sv
module rfd_history #(
  parameter int QW = rfd_pkg::QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [QW-1:0] cur_i,
  output logic [QW-1:0] prev_o,
  output logic          prev_ok_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_o    <= '0;
      prev_ok_o <= 1'b0;
    end else if (load_i) begin
      prev_o    <= cur_i;
      prev_ok_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rfd_steer.sv
module rfd_steer #(
  parameter int QW = rfd_pkg::QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic          prev_ok_i,
  input  logic [QW-1:0] prev_i,
  input  logic [QW-1:0] cur_i,
  output logic          up_o,
  output logic          dn_o
);
  import rfd_pkg::*;

  // The watched boundary: code 0...0 and its Gray neighbour 1 0...0.
  localparam logic [QW-1:0] CODE_LOW  = '0;
  localparam logic [QW-1:0] CODE_HIGH = {1'b1, {(QW-1){1'b0}}};

  steer_e decide;

  always_comb begin
    decide = STEER_NONE;
    if (fire_i && prev_ok_i) begin
      if (prev_i == CODE_HIGH && cur_i == CODE_LOW)
        decide = STEER_UP;
      else if (prev_i == CODE_LOW && cur_i == CODE_HIGH)
        decide = STEER_DN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= (decide == STEER_UP);
      dn_o <= (decide == STEER_DN);
    end
  end
endmodule

// File: rtl/rfd_top.sv
module rfd_top #(
  parameter int NPH = rfd_pkg::PH_N,
  localparam int QW = NPH / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic [NPH-1:0] smp_phase,
  output logic           up_o,
  output logic           dn_o
);
  logic [QW-1:0] cur_q;
  logic [QW-1:0] prev_q;
  logic          prev_ok;

  rfd_quadrant #(.NPH(NPH)) u_quad (
    .phase_i (smp_phase),
    .quad_o  (cur_q)
  );

  rfd_history #(.QW(QW)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .load_i    (smp_valid),
    .cur_i     (cur_q),
    .prev_o    (prev_q),
    .prev_ok_o (prev_ok)
  );

  rfd_steer #(.QW(QW)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (smp_valid),
    .prev_ok_i (prev_ok),
    .prev_i    (prev_q),
    .cur_i     (cur_q),
    .up_o      (up_o),
    .dn_o      (dn_o)
  );
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
  parameter int QW = rfd_pkg::QW
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [QW-1:0] cur_q,
  input logic [QW-1:0] prev_q,
  input logic          prev_ok,
  input logic          up_o,
  input logic          dn_o
);
  localparam logic [QW-1:0] C_LOW  = '0;
  localparam logic [QW-1:0] C_HIGH = {1'b1, {(QW-1){1'b0}}};

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o));

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    up_o |=> !up_o);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dn_o |=> !dn_o);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!up_o && !dn_o));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(prev_q));

  a_r7_first_silent: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !prev_ok) |=> (!up_o && !dn_o));

  a_r5_still_quiet: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && cur_q == prev_q) |=> (!up_o && !dn_o));

  a_r3_up_cause: assert property (@(posedge clk) disable iff (rst)
    up_o |-> ($past(smp_valid) && $past(prev_q) == C_HIGH && $past(cur_q) == C_LOW));

  a_r4_dn_cause: assert property (@(posedge clk) disable iff (rst)
    dn_o |-> ($past(smp_valid) && $past(prev_q) == C_LOW && $past(cur_q) == C_HIGH));
endmodule

bind rfd_top rfd_checker #(.QW(QW)) u_rfd_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .cur_q     (cur_q),
  .prev_q    (prev_q),
  .prev_ok   (prev_ok),
  .up_o      (up_o),
  .dn_o      (dn_o)
);

// File: tb/rfd_top_bench.sv
`timescale 1ns/1ps
module rfd_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [3:0] smp_phase = 4'b0000;
  logic       up_o, dn_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rfd_top u_rfd_top (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_phase (smp_phase),
    .up_o      (up_o),
    .dn_o      (dn_o)
  );

  // {smp_phase[3:0], exp_up, exp_dn}; walked right after a reset.
  localparam logic [5:0] VEC [15] = '{
    {4'b1111, 2'b00},  // 00 first beat
    {4'b0001, 2'b01},  // 00->10 down
    {4'b0000, 2'b10},  // 10->00 up
    {4'b0111, 2'b00},  // 00->01
    {4'b1100, 2'b00},  // 01->11
    {4'b1110, 2'b00},  // 11->10
    {4'b1111, 2'b10},  // 10->00 up
    {4'b1111, 2'b00},  // 00->00 hold
    {4'b1110, 2'b01},  // 00->10 down
    {4'b1100, 2'b00},  // 10->11
    {4'b0001, 2'b00},  // 11->10
    {4'b0000, 2'b10},  // 10->00 up
    {4'b0011, 2'b00},  // 00->11 skip
    {4'b1110, 2'b00},  // 11->10
    {4'b0111, 2'b00}   // 10->01
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {up,dn} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Present one beat; outputs are observed at the following negedge.
  task automatic strobe(input logic [3:0] s);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_phase = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [3:0] phase_bits(input int theta);
    logic [3:0] b;
    for (int k = 0; k < 4; k++) b[k] = (((theta + 45*k) % 360) < 180);
    return b;
  endfunction

  function automatic logic [1:0] quad_of(input logic [3:0] s);
    return {s[0] ^ s[2], s[1] ^ s[3]};
  endfunction

  task automatic sweep(input int step, input logic [1:0] exp_sides);
    int ups = 0;
    int dns = 0;
    int theta = 7;
    logic [1:0] prevq = 2'b00;
    bit have = 1'b0;
    do_reset();
    for (int n = 0; n < 40; n++) begin
      logic [3:0] s;
      logic [1:0] q;
      logic [1:0] e;
      s = phase_bits(theta);
      q = quad_of(s);
      e = {have && prevq == 2'b10 && q == 2'b00, have && prevq == 2'b00 && q == 2'b10};
      strobe(s);
      check("R8 sweep beat", {up_o, dn_o}, e);
      if (up_o) ups++;
      if (dn_o) dns++;
      prevq = q;
      have = 1'b1;
      theta = (((theta + step) % 360) + 360) % 360;
    end
    check("R8 direction", {ups > 0, dns > 0}, exp_sides);
  endtask

  initial begin
    // R7: outputs low during reset
    @(negedge clk);
    @(negedge clk);
    check("R7 reset state", {up_o, dn_o}, 2'b00);
    rst = 1'b0;

    // Table walk: R1 encoding, R3/R4/R5 pairs, R7 first beat
    for (int i = 0; i < 15; i++) begin
      logic [1:0] e;
      e = VEC[i][1:0];
      strobe(VEC[i][5:2]);
      if (i == 0) check("R7 first beat", {up_o, dn_o}, e);
      else if (e == 2'b10) check("R1/R3 up", {up_o, dn_o}, e);
      else if (e == 2'b01) check("R1/R4 down", {up_o, dn_o}, e);
      else check("R1/R5 none", {up_o, dn_o}, e);
      if (e != 2'b00) begin
        @(negedge clk);
        check("R3/R4 width", {up_o, dn_o}, 2'b00);
      end
    end

    // R2: idle cycles with crossing-shaped bits must not be taken
    do_reset();
    strobe(4'b1111);
    smp_phase = 4'b0001;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R2 idle", {up_o, dn_o}, 2'b00);
    end
    strobe(4'b1111);
    check("R2 history kept", {up_o, dn_o}, 2'b00);
    strobe(4'b0001);
    check("R4 after idle", {up_o, dn_o}, 2'b01);

    // R7: reset mid-run forgets quadrant 10
    do_reset();
    strobe(4'b0000);
    check("R7 reset forgets", {up_o, dn_o}, 2'b00);

    // R6/R8: frequency sweeps
    sweep(18, 2'b10);
    sweep(36, 2'b10);
    sweep(-18, 2'b01);
    sweep(-36, 2'b01);
    sweep(0, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule